// File: doc/BRIEF.md
# Serial Port FIFO Register Interface

This block is the register-mapped front end of a synchronous serial port. A 32-bit word bus reaches four 16-bit registers: two control registers, a status register and one data register. The data register is shared by both directions. A write to it queues a frame in an 8-entry transmit FIFO, and a read from it takes the oldest word from a separate 8-entry receive FIFO. Because the two FIFOs are independent, the port runs full duplex.

Frames are 4 to 16 bits long and sit left-justified in the low half-word. A built-in serializer shifts queued frames out MSB first, at a programmable number of system clocks per bit. For each bit sent it captures one bit, taken either from the serial input or from its own output in loopback. Each direction has a half-FIFO service level. That level drives either a CPU interrupt or a dedicated DMA request, depending on the servicing mode. A sticky receive overrun flag has its own interrupt.

Register map (word index on `bus_addr`): 0 = CTRL0, 1 = CTRL1, 2 = DATA, 3 = STAT.

Top module: `ssp_regif`

## Requirements
- R1: Every register read returns zero in bits 31:16. CTRL0 keeps bits 6:0 of the written word: [3:0] size code, [4] enable, [5] loopback, [6] DMA mode. CTRL1 keeps bits 7:0 (divider code). Write bits above these fields have no effect on readback.
- R2: A write to DATA pushes bits 15:0 into the transmit FIFO. A write is dropped when that FIFO already holds 8 entries. A read of DATA returns the oldest receive word and removes it. A read of an empty receive FIFO returns zero and changes nothing.
- R3: The frame length is the size code plus one. Size codes below 3 act as 3, giving a 4-bit frame. Transmit takes bits 15 downward. Received frames are returned left-justified with all unused low bits zero.
- R4: `txd` is low when idle. Each frame goes out MSB first, and each bit is held for the divider code plus one clocks.
- R5: With loopback set, received bits are the port's own transmitted bits. Otherwise they are sampled from `rxd` once per bit, at the end of each bit period.
- R6: Each FIFO holds 8 entries. STAT[1] (transmit not full) is low exactly while the transmit FIFO holds 8 entries.
- R7: Transmit service (STAT[3]) is high while the port is enabled and the transmit FIFO holds 4 or fewer entries. Receive service (STAT[4]) is high while the receive FIFO holds 4 or more entries.
- R8: With CTRL0[6] clear, `irq_tx`/`irq_rx` follow transmit and receive service and both DMA requests stay low. With CTRL0[6] set, `dma_tx_req`/`dma_rx_req` follow them and those two interrupts stay low.
- R9: STAT[5] (overrun) and `irq_ovr` are set when a frame completes while the receive FIFO is full, and that frame is discarded. The flag is cleared only by writing DATA bit 5 = 1 to STAT. Writing 0 there leaves it set.
- R10: STAT[2] (busy) is high while the port is enabled and either a frame is shifting or the transmit FIFO is not empty.
- R11: While CTRL0[4] is clear, both FIFOs are held empty, shifting stops and busy is low. STAT[0] is receive not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data, low half-word used |
| bus_rdata | output | 32 | Read data, valid while `bus_sel` is high |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| irq_tx | output | 1 | Transmit service interrupt |
| irq_rx | output | 1 | Receive service interrupt |
| irq_ovr | output | 1 | Receive overrun interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The assertions assume that bus accesses are single-cycle strobes whose address and data are stable for that cycle. They also assume that each assertion's FIFO input pattern comes only through the register decode, so push and pop never arrive from anywhere else. The bench issues every access as a one-cycle strobe set up at the falling edge. It changes CTRL0 and CTRL1 only while the port is idle or being disabled, so a frame never sees its length or divider change midway. The one exception is the flush test, which disables the port while frames are queued, on purpose.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    REG_CTRL0 = 2'd0,
    REG_CTRL1 = 2'd1,
    REG_DATA  = 2'd2,
    REG_STAT  = 2'd3
  } reg_addr_e;

  localparam int ST_RX_NE  = 0;
  localparam int ST_TX_NF  = 1;
  localparam int ST_BUSY   = 2;
  localparam int ST_TX_SVC = 3;
  localparam int ST_RX_SVC = 4;
  localparam int ST_OVR    = 5;
  localparam int ST_BITS   = 6;

  localparam int C0_EN   = 4;
  localparam int C0_LOOP = 5;
  localparam int C0_DMA  = 6;
  localparam int C0_BITS = 7;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [PW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;
  logic [W-1:0]  slots [DEPTH];

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign count   = cnt_q;
  assign dout    = slots[rd_q];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (do_push && (wr_q == PW'(i))) slot_q <= din;
    end
    assign slots[i] = slot_q;
  end

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_n = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_n = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (count == CW'(DEPTH)));
  // R2
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> empty);
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int DW   = 16,
  parameter int DIVW = 8,
  localparam int SZW = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            loopback,
  input  logic [SZW-1:0]  size_m1,
  input  logic [DIVW-1:0] div_m1,
  input  logic            tx_avail,
  input  logic [DW-1:0]   tx_data,
  input  logic            rxd,
  output logic            tx_pop,
  output logic            txd,
  output logic            active,
  output logic            rx_done,
  output logic [DW-1:0]   rx_word
);
  logic            active_q, active_n;
  logic [DW-1:0]   tx_sh_q, tx_sh_n, rx_sh_q, rx_sh_n;
  logic [SZW-1:0]  bits_q, bits_n, size_q, size_n;
  logic [DIVW-1:0] div_cnt_q, div_cnt_n, div_q, div_n;
  logic            tick, rx_bit;
  logic [DW-1:0]   rx_cat;

  assign tick   = active_q && (div_cnt_q == div_q);
  assign rx_bit = loopback ? tx_sh_q[DW-1] : rxd;
  assign rx_cat = {rx_sh_q[DW-2:0], rx_bit};

  always_comb begin
    active_n  = active_q;
    tx_sh_n   = tx_sh_q;
    rx_sh_n   = rx_sh_q;
    bits_n    = bits_q;
    size_n    = size_q;
    div_cnt_n = div_cnt_q;
    div_n     = div_q;
    tx_pop    = 1'b0;
    rx_done   = 1'b0;
    if (!en) begin
      active_n = 1'b0;
    end else if (!active_q) begin
      if (tx_avail) begin
        active_n  = 1'b1;
        tx_sh_n   = tx_data;
        rx_sh_n   = '0;
        bits_n    = size_m1;
        size_n    = size_m1;
        div_n     = div_m1;
        div_cnt_n = '0;
        tx_pop    = 1'b1;
      end
    end else if (tick) begin
      div_cnt_n = '0;
      rx_sh_n   = rx_cat;
      tx_sh_n   = {tx_sh_q[DW-2:0], 1'b0};
      if (bits_q == '0) begin
        active_n = 1'b0;
        rx_done  = 1'b1;
      end else begin
        bits_n = bits_q - 1'b1;
      end
    end else begin
      div_cnt_n = div_cnt_q + 1'b1;
    end
  end

  assign rx_word = rx_cat << (SZW'(DW - 1) - size_q);
  assign txd     = active_q & tx_sh_q[DW-1];
  assign active  = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      bits_q    <= '0;
      size_q    <= '0;
      div_cnt_q <= '0;
      div_q     <= '0;
    end else begin
      active_q  <= active_n;
      tx_sh_q   <= tx_sh_n;
      rx_sh_q   <= rx_sh_n;
      bits_q    <= bits_n;
      size_q    <= size_n;
      div_cnt_q <= div_cnt_n;
      div_q     <= div_n;
    end
  end

  // R4
  txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && active_q && !tick) |=> $stable(txd));
  // R4
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !(en && tx_avail)) |=> (!txd || active_q));
endmodule

// File: rtl/ssp_regif.sv
module ssp_regif #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int DIVW  = 8,
  parameter int BUSW  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [BUSW-1:0] bus_wdata,
  output logic [BUSW-1:0] bus_rdata,
  output logic            txd,
  input  logic            rxd,
  output logic            irq_tx,
  output logic            irq_rx,
  output logic            irq_ovr,
  output logic            dma_tx_req,
  output logic            dma_rx_req
);
  import ssp_pkg::*;

  localparam int SZW    = $clog2(DW);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int HALF   = DEPTH / 2;
  localparam int MIN_M1 = 3;

  logic [C0_BITS-1:0] ctrl0_q, ctrl0_n;
  logic [DIVW-1:0]    ctrl1_q, ctrl1_n;
  logic               ovr_q, ovr_n;

  logic wr_hit, rd_hit, en, tx_push, rx_pop;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] tx_head, rx_head, rx_word;
  logic sh_pop, sh_active, sh_done;
  logic [SZW-1:0] size_m1;
  logic busy, tx_svc, rx_svc, dma_mode;
  logic [ST_BITS-1:0] status;

  assign wr_hit   = bus_sel && bus_wr;
  assign rd_hit   = bus_sel && !bus_wr;
  assign en       = ctrl0_q[C0_EN];
  assign dma_mode = ctrl0_q[C0_DMA];
  assign tx_push  = wr_hit && (bus_addr == REG_DATA);
  assign rx_pop   = rd_hit && (bus_addr == REG_DATA);
  assign size_m1  = (ctrl0_q[SZW-1:0] < SZW'(MIN_M1)) ? SZW'(MIN_M1)
                                                      : ctrl0_q[SZW-1:0];

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) i_tx_fifo (
    .clk, .rst_n, .flush(!en),
    .push(tx_push), .din(bus_wdata[DW-1:0]), .pop(sh_pop),
    .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) i_rx_fifo (
    .clk, .rst_n, .flush(!en),
    .push(sh_done), .din(rx_word), .pop(rx_pop),
    .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  ssp_shifter #(.DW(DW), .DIVW(DIVW)) i_shifter (
    .clk, .rst_n, .en, .loopback(ctrl0_q[C0_LOOP]),
    .size_m1, .div_m1(ctrl1_q), .tx_avail(!tx_empty), .tx_data(tx_head),
    .rxd, .tx_pop(sh_pop), .txd, .active(sh_active),
    .rx_done(sh_done), .rx_word
  );

  assign busy   = en && (sh_active || !tx_empty);
  assign tx_svc = en && (tx_cnt <= CW'(HALF));
  assign rx_svc = en && (rx_cnt >= CW'(HALF));

  always_comb begin
    status            = '0;
    status[ST_RX_NE]  = !rx_empty;
    status[ST_TX_NF]  = !tx_full;
    status[ST_BUSY]   = busy;
    status[ST_TX_SVC] = tx_svc;
    status[ST_RX_SVC] = rx_svc;
    status[ST_OVR]    = ovr_q;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_CTRL0: bus_rdata[C0_BITS-1:0] = ctrl0_q;
      REG_CTRL1: bus_rdata[DIVW-1:0]    = ctrl1_q;
      REG_DATA:  bus_rdata[DW-1:0]      = rx_empty ? '0 : rx_head;
      REG_STAT:  bus_rdata[ST_BITS-1:0] = status;
      default:   bus_rdata = '0;
    endcase
  end

  always_comb begin
    ctrl0_n = ctrl0_q;
    ctrl1_n = ctrl1_q;
    ovr_n   = ovr_q;
    if (wr_hit && (bus_addr == REG_CTRL0)) ctrl0_n = bus_wdata[C0_BITS-1:0];
    if (wr_hit && (bus_addr == REG_CTRL1)) ctrl1_n = bus_wdata[DIVW-1:0];
    if (sh_done && rx_full)
      ovr_n = 1'b1;
    else if (wr_hit && (bus_addr == REG_STAT) && bus_wdata[ST_OVR])
      ovr_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      ctrl0_q <= ctrl0_n;
      ctrl1_q <= ctrl1_n;
      ovr_q   <= ovr_n;
    end
  end

  assign irq_tx     = tx_svc && !dma_mode;
  assign irq_rx     = rx_svc && !dma_mode;
  assign dma_tx_req = tx_svc && dma_mode;
  assign dma_rx_req = rx_svc && dma_mode;
  assign irq_ovr    = ovr_q;

  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && rx_full) |=> irq_ovr);
  // R9
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovr && !(wr_hit && (bus_addr == REG_STAT) && bus_wdata[ST_OVR])) |=> irq_ovr);
  // R11
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && rx_empty && tx_empty));
  // R8
  svc_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_tx, dma_tx_req, irq_rx && dma_tx_req}) && $onehot0({irq_rx, dma_rx_req}));
endmodule

// File: tb/test_ssp_regif.sv
module test_ssp_regif;
  logic        clk, rst_n, bus_sel, bus_wr, rxd;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic txd, irq_tx, irq_rx, irq_ovr, dma_tx_req, dma_rx_req;

  localparam logic [1:0] A_C0 = 2'd0, A_C1 = 2'd1, A_DAT = 2'd2, A_ST = 2'd3;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];

  ssp_regif i_ssp_regif (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  // driver: queue the expected receive word, then push the frame
  task automatic send(input logic [15:0] d, input logic [31:0] exp);
    exp_q.push_back(exp);
    bus_write(A_DAT, {16'hDEAD, d});
  endtask

  // monitor: pop words as they arrive and compare with the queue
  task automatic drain(input string req);
    logic [31:0] st, d, e;
    while (exp_q.size() > 0) begin
      int polls = 0;
      do begin
        bus_read(A_ST, st);
        polls++;
      end while (!st[0] && polls < 20000);
      bus_read(A_DAT, d);
      e = exp_q.pop_front();
      chk(req, d, e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic smp [40];
    int f;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; rxd = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;

    // reset state
    bus_read(A_ST, r);  chk("R6 reset status", r, 32'h2);
    bus_read(A_C0, r);  chk("R1 reset ctrl0", r, 32'h0);
    chk("R8 reset outputs", {27'd0, irq_tx, irq_rx, irq_ovr, dma_tx_req, dma_rx_req}, 32'h0);
    chk("R4 idle txd", {31'd0, txd}, 32'h0);
    bus_read(A_DAT, r); chk("R2 empty read", r, 32'h0);

    // R1 register width and upper bits
    bus_write(A_C1, 32'h1234_5603);
    bus_read(A_C1, r);  chk("R1 ctrl1 readback", r, 32'h0000_0003);
    bus_write(A_C0, 32'hFFFF_FF80);
    bus_read(A_C0, r);  chk("R1 ctrl0 readback", r, 32'h0);

    // R3 R2 loopback, 8-bit frames, divider 2
    bus_write(A_C1, 32'h1);
    bus_write(A_C0, 32'h37);
    @(negedge clk);
    chk("R8 irq_tx with empty fifo", {31'd0, irq_tx}, 32'h1);
    send(16'h12AB, 32'h1200);
    send(16'h34CD, 32'h3400);
    send(16'hFFFF, 32'hFF00);
    drain("R3 8-bit loopback");

    bus_write(A_C0, 32'h3F);
    send(16'hBEEF, 32'hBEEF);
    send(16'h0001, 32'h0001);
    drain("R3 16-bit loopback");
    bus_write(A_C0, 32'h33);
    send(16'hABCD, 32'hA000);
    drain("R3 4-bit loopback");
    bus_write(A_C0, 32'h31);
    send(16'h5FFF, 32'h5000);
    drain("R3 size code clamp");

    // R4 bit timing: 4 clocks per bit, 4-bit frame 1010
    bus_write(A_C1, 32'h3);
    bus_write(A_C0, 32'h33);
    exp_q.push_back(32'hA000);
    fork
      bus_write(A_DAT, 32'h0000_A000);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        smp[k] = txd;
      end
    join
    f = 0;
    for (int k = 39; k >= 0; k--) if (smp[k]) f = k;
    chk("R4 bit0", {31'd0, smp[f+1]}, 32'h1);
    chk("R4 bit1", {31'd0, smp[f+5]}, 32'h0);
    chk("R4 bit2", {31'd0, smp[f+9]}, 32'h1);
    chk("R4 bit2 held", {31'd0, smp[f+11]}, 32'h1);
    chk("R4 bit3 and idle", {30'd0, smp[f+13], smp[f+17]}, 32'h0);
    drain("R4 loopback word");

    // R5 external receive
    bus_write(A_C1, 32'h1);
    bus_write(A_C0, 32'h17);
    rxd = 1;
    send(16'h00AA, 32'hFF00);
    drain("R5 rxd high");
    rxd = 0;
    send(16'hFFFF, 32'h0000);
    drain("R5 rxd low");

    // R6 R7 R10 slow divider, overfill transmit FIFO
    bus_write(A_C1, 32'hFF);
    bus_write(A_C0, 32'h37);
    for (int k = 0; k < 10; k++) begin
      if (k < 9) send(16'(16'h0100 * (k + 1)), 32'(16'h0100 * (k + 1)));
      else bus_write(A_DAT, 32'h0000_EE00);
    end
    bus_read(A_ST, r);
    chk("R6 R10 status full busy", r, 32'h4);
    chk("R7 irq_tx low when full", {31'd0, irq_tx}, 32'h0);
    begin
      int w = 0;
      while (!irq_tx && w < 20000) begin @(negedge clk); w++; end
    end
    chk("R7 tx service level", {31'd0, irq_tx}, 32'h1);
    chk("R7 rx service level", {31'd0, irq_rx}, 32'h1);
    drain("R2 overfill drop");
    repeat (3000) @(negedge clk);
    bus_read(A_ST, r);
    chk("R10 idle after drain", r, 32'hA);

    // R9 overrun
    bus_write(A_C1, 32'h1);
    for (int k = 0; k < 8; k++) send(16'(16'h1100 * (k + 1)), 32'(16'h1100 * (k + 1)));
    repeat (300) @(negedge clk);
    bus_write(A_DAT, 32'h0000_5500);
    bus_write(A_DAT, 32'h0000_6600);
    repeat (100) @(negedge clk);
    chk("R9 irq_ovr set", {31'd0, irq_ovr}, 32'h1);
    bus_write(A_ST, 32'h0000_001F);
    bus_read(A_ST, r);
    chk("R9 zero write keeps flag", {31'd0, r[5]}, 32'h1);
    bus_write(A_ST, 32'h0000_0020);
    chk("R9 flag cleared", {31'd0, irq_ovr}, 32'h0);
    drain("R9 discarded frames");

    // R8 DMA routing
    bus_write(A_C0, 32'h77);
    @(negedge clk);
    chk("R8 dma tx", {30'd0, dma_tx_req, irq_tx}, 32'h2);
    for (int k = 0; k < 4; k++) send(16'(16'h2200 + k * 16'h0100), 32'(16'h2200 + k * 16'h0100));
    repeat (150) @(negedge clk);
    chk("R8 dma rx", {30'd0, dma_rx_req, irq_rx}, 32'h2);
    drain("R8 dma words");

    // R11 disable flushes
    bus_write(A_C1, 32'hFF);
    bus_write(A_C0, 32'h37);
    for (int k = 0; k < 5; k++) bus_write(A_DAT, 32'h0000_7700);
    repeat (10) @(negedge clk);
    bus_write(A_C0, 32'h27);
    bus_read(A_ST, r);
    chk("R11 flushed status", r, 32'h2);
    chk("R11 txd low", {31'd0, txd}, 32'h0);
    bus_write(A_C0, 32'h37);
    repeat (3000) @(negedge clk);
    bus_read(A_ST, r);
    chk("R11 nothing left to send", r, 32'hA);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule